// File: doc/BRIEF.md
# Opcode Decoder with Cycle Costing

This block is the combinational front end of an 8-bit accumulator processor. It takes one opcode byte and the zero and carry flags. It reports the instruction class, the register indices the instruction names, the ALU operation, and the branch condition with its evaluated outcome. It also reports the cost in cycles for both branch outcomes and for the current flags, the restart target, and side effects: high-page addressing, the prefix escape, setting or clearing the interrupt master enable, and illegal opcodes.

The opcode is read as three fields: group `op[7:6]`, field `a = op[5:3]` and field `b = op[2:0]`. The sequencer registers these outputs and uses `cyc_o` to time the instruction. It treats `illegal_o` as a trap.

Top module: `opdec_core`

## Requirements
- R1: Group 01, except 0x76, gives class 3 (register move) with dst_o=a and src_o=b. It costs 4 cycles, or 8 when a or b equals 6.
- R2: Opcode 0x76 gives class 4 (halt) at a cost of 4 cycles.
- R3: Group 10 gives class 5 with alu_op_o=a, src_o=b and dst_o=7, costing 4 cycles or 8 when b=6. Group 11 with b=6 gives class 6 (ALU with immediate) with alu_op_o=a and dst_o=7, costing 8.
- R4: The condition code is op[4:3]: 0 means zero flag clear, 1 zero set, 2 carry clear, 3 carry set. taken_o is 1 only for a conditional opcode whose condition holds. cond_o shows the code, and reads 0 for unconditional opcodes.
- R5: Conditional opcodes are 0x20/28/30/38 (class 7, relative jump), 0xC2/CA/D2/DA (class 8, jump), 0xC4/CC/D4/DC (class 10, call) and 0xC0/C8/D0/D8 (class 11, return). Their taken/skip costs are 12/8, 16/12, 24/12 and 20/8. cyc_o gives the cost for the current flags.
- R6: The unconditional flow opcodes and their costs are 0x18 class 7 (12), 0xC3 class 8 (16), 0xE9 class 9 (4), 0xCD class 10 (24), 0xC9 class 11 (16) and 0xD9 class 12 (16). 0xD9 also sets ime_set_o. For every unconditional opcode the taken cost equals the skip cost.
- R7: Group 11 with b=7 gives class 13 (restart), costing 16, with rst_vec_o = a×8. rst_vec_o is 0 for all other opcodes.
- R8: 0xE0/0xE2 give class 16 (store to page 0xFF00) and 0xF0/0xF2 give class 17 (load from that page). The immediate forms cost 12 with hp_c_o=0; the register-C forms cost 8 with hp_c_o=1.
- R9: 0xCB gives class 18 with prefix_o=1 and costs 4. 0xF3 gives class 19 with ime_clr_o=1, and 0xFB gives class 20 with ime_set_o=1; both cost 4.
- R10: 0xD3, DB, DD, E3, E4, EB, EC, ED, F4, FC and FD raise illegal_o. For these, class is 0 and every other output is 0.
- R11: 0x00 gives class 1 (no-op) at a cost of 4. The rest of group 00, other than the jumps, is class 2 and costs as follows: 0x08 costs 20 and 0x10 costs 4. With b=1 the cost is 12 for even a and 8 for odd a. b=2 and b=3 cost 8. b=4 and b=5 cost 4, or 12 when a=6. b=6 costs 8, or 12 when a=6. b=7 costs 4.
- R12: Group 11 with b=1 and even a gives class 15 (pop, 12 cycles) with dst_o=a>>1. b=5 with even a gives class 14 (push, 16 cycles) with src_o=a>>1. 0xE8 costs 16, 0xF8 costs 12, 0xF9 costs 8, and 0xEA/0xFA cost 16, all class 2. Outputs not named in a requirement are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 8 | Opcode byte |
| zf_i | input | 1 | Zero flag |
| cf_i | input | 1 | Carry flag |
| class_o | output | 5 | Instruction class code |
| src_o | output | 3 | Source register or pair index |
| dst_o | output | 3 | Destination register or pair index |
| alu_op_o | output | 3 | ALU operation select |
| cond_o | output | 2 | Condition code |
| cond_used_o | output | 1 | Opcode is conditional |
| taken_o | output | 1 | Condition holds |
| cyc_taken_o | output | 5 | Cost when taken |
| cyc_skip_o | output | 5 | Cost when not taken |
| cyc_o | output | 5 | Cost for current flags |
| rst_vec_o | output | 8 | Restart target address |
| hp_c_o | output | 1 | High-page low byte comes from register C |
| prefix_o | output | 1 | Prefix escape |
| ime_set_o | output | 1 | Set interrupt master enable |
| ime_clr_o | output | 1 | Clear interrupt master enable |
| illegal_o | output | 1 | Undefined opcode |

## Verification
The hardest cases are the conditional opcodes, where cyc_o and taken_o must follow flags that are independent of the opcode. A sweep that holds the flags constant would never reach a case where a taken cost is wrong. The stimulus therefore applies every one of the 256 opcodes under all four zero/carry combinations. Each output is compared against a behavioural table of opcode values.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  parameter int unsigned CYCW = 5;
  parameter int unsigned FLDW = 3;

  typedef enum logic [4:0] {
    CL_NONE   = 5'd0,  CL_NOP   = 5'd1,  CL_MISC  = 5'd2,  CL_LDRR  = 5'd3,
    CL_HALT   = 5'd4,  CL_ALUR  = 5'd5,  CL_ALUI  = 5'd6,  CL_JR    = 5'd7,
    CL_JP     = 5'd8,  CL_JPHL  = 5'd9,  CL_CALL  = 5'd10, CL_RET   = 5'd11,
    CL_RETI   = 5'd12, CL_RST   = 5'd13, CL_PUSH  = 5'd14, CL_POP   = 5'd15,
    CL_LDHST  = 5'd16, CL_LDHLD = 5'd17, CL_PREFIX= 5'd18, CL_DI    = 5'd19,
    CL_EI     = 5'd20
  } cls_e;

  typedef struct packed {
    cls_e            cls;
    logic [FLDW-1:0] src;
    logic [FLDW-1:0] dst;
    logic [FLDW-1:0] alu;
    logic            cond_used;
    logic [CYCW-1:0] cyc_t;
    logic [CYCW-1:0] cyc_n;
    logic            hp_c;
    logic            prefix;
    logic            ime_set;
    logic            ime_clr;
    logic            illegal;
  } dec_t;
endpackage

// File: rtl/opdec_cond.sv
module opdec_cond (
  input  logic       zf_i,
  input  logic       cf_i,
  input  logic [1:0] sel_i,
  output logic       hold_o
);
  logic [3:0] hit;
  // lane i: bit1 picks flag (0=zero,1=carry), bit0 picks wanted level
  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign hit[i] = (((i / 2) == 1) ? cf_i : zf_i) == ((i % 2) == 1);
  end
  assign hold_o = hit[sel_i];
endmodule

// File: rtl/opdec_lo.sv
module opdec_lo
  import opdec_pkg::*;
(
  input  logic [7:0] op_i,
  output dec_t       d_o
);
  logic [2:0] a, b;
  assign a = op_i[5:3];
  assign b = op_i[2:0];

  always_comb begin
    d_o     = '0;
    d_o.cls = CL_NONE;
    unique case (op_i[7:6])
      2'b00: begin
        d_o.cls = CL_MISC;
        unique case (b)
          3'd0: begin
            unique case (a)
              3'd0: begin d_o.cls = CL_NOP; d_o.cyc_t = CYCW'(4); end
              3'd1: d_o.cyc_t = CYCW'(20);
              3'd2: d_o.cyc_t = CYCW'(4);
              3'd3: begin d_o.cls = CL_JR; d_o.cyc_t = CYCW'(12); end
              default: begin
                d_o.cls       = CL_JR;
                d_o.cond_used = 1'b1;
                d_o.cyc_t     = CYCW'(12);
                d_o.cyc_n     = CYCW'(8);
              end
            endcase
          end
          3'd1:        d_o.cyc_t = a[0] ? CYCW'(8) : CYCW'(12);
          3'd2, 3'd3:  d_o.cyc_t = CYCW'(8);
          3'd4, 3'd5:  d_o.cyc_t = (a == 3'd6) ? CYCW'(12) : CYCW'(4);
          3'd6:        d_o.cyc_t = (a == 3'd6) ? CYCW'(12) : CYCW'(8);
          default:     d_o.cyc_t = CYCW'(4);
        endcase
      end
      2'b01: begin
        if (a == 3'd6 && b == 3'd6) begin
          d_o.cls   = CL_HALT;
          d_o.cyc_t = CYCW'(4);
        end else begin
          d_o.cls   = CL_LDRR;
          d_o.dst   = a;
          d_o.src   = b;
          d_o.cyc_t = (a == 3'd6 || b == 3'd6) ? CYCW'(8) : CYCW'(4);
        end
      end
      2'b10: begin
        d_o.cls   = CL_ALUR;
        d_o.alu   = a;
        d_o.src   = b;
        d_o.dst   = 3'd7;
        d_o.cyc_t = (b == 3'd6) ? CYCW'(8) : CYCW'(4);
      end
      default: d_o.cls = CL_NONE;
    endcase
    if (!d_o.cond_used) d_o.cyc_n = d_o.cyc_t;
  end
endmodule

// File: rtl/opdec_hi.sv
module opdec_hi
  import opdec_pkg::*;
(
  input  logic [5:0] op_i,
  output dec_t       d_o
);
  logic [2:0] a, b;
  assign a = op_i[5:3];
  assign b = op_i[2:0];

  always_comb begin
    d_o     = '0;
    d_o.cls = CL_NONE;
    unique case (b)
      3'd0: begin
        if (!a[2]) begin
          d_o.cls = CL_RET; d_o.cond_used = 1'b1;
          d_o.cyc_t = CYCW'(20); d_o.cyc_n = CYCW'(8);
        end else begin
          unique case (a[1:0])
            2'd0: begin d_o.cls = CL_LDHST; d_o.cyc_t = CYCW'(12); end
            2'd1: begin d_o.cls = CL_MISC;  d_o.cyc_t = CYCW'(16); end
            2'd2: begin d_o.cls = CL_LDHLD; d_o.cyc_t = CYCW'(12); end
            default: begin d_o.cls = CL_MISC; d_o.cyc_t = CYCW'(12); end
          endcase
        end
      end
      3'd1: begin
        if (!a[0]) begin
          d_o.cls = CL_POP; d_o.dst = {1'b0, a[2:1]}; d_o.cyc_t = CYCW'(12);
        end else begin
          unique case (a[2:1])
            2'd0: begin d_o.cls = CL_RET;  d_o.cyc_t = CYCW'(16); end
            2'd1: begin d_o.cls = CL_RETI; d_o.cyc_t = CYCW'(16); d_o.ime_set = 1'b1; end
            2'd2: begin d_o.cls = CL_JPHL; d_o.cyc_t = CYCW'(4); end
            default: begin d_o.cls = CL_MISC; d_o.cyc_t = CYCW'(8); end
          endcase
        end
      end
      3'd2: begin
        if (!a[2]) begin
          d_o.cls = CL_JP; d_o.cond_used = 1'b1;
          d_o.cyc_t = CYCW'(16); d_o.cyc_n = CYCW'(12);
        end else begin
          unique case (a[1:0])
            2'd0: begin d_o.cls = CL_LDHST; d_o.cyc_t = CYCW'(8); d_o.hp_c = 1'b1; end
            2'd2: begin d_o.cls = CL_LDHLD; d_o.cyc_t = CYCW'(8); d_o.hp_c = 1'b1; end
            default: begin d_o.cls = CL_MISC; d_o.cyc_t = CYCW'(16); end
          endcase
        end
      end
      3'd3: begin
        unique case (a)
          3'd0: begin d_o.cls = CL_JP;     d_o.cyc_t = CYCW'(16); end
          3'd1: begin d_o.cls = CL_PREFIX; d_o.cyc_t = CYCW'(4); d_o.prefix = 1'b1; end
          3'd6: begin d_o.cls = CL_DI;     d_o.cyc_t = CYCW'(4); d_o.ime_clr = 1'b1; end
          3'd7: begin d_o.cls = CL_EI;     d_o.cyc_t = CYCW'(4); d_o.ime_set = 1'b1; end
          default: d_o.illegal = 1'b1;
        endcase
      end
      3'd4: begin
        if (!a[2]) begin
          d_o.cls = CL_CALL; d_o.cond_used = 1'b1;
          d_o.cyc_t = CYCW'(24); d_o.cyc_n = CYCW'(12);
        end else begin
          d_o.illegal = 1'b1;
        end
      end
      3'd5: begin
        if (!a[0]) begin
          d_o.cls = CL_PUSH; d_o.src = {1'b0, a[2:1]}; d_o.cyc_t = CYCW'(16);
        end else if (a == 3'd1) begin
          d_o.cls = CL_CALL; d_o.cyc_t = CYCW'(24);
        end else begin
          d_o.illegal = 1'b1;
        end
      end
      3'd6: begin
        d_o.cls = CL_ALUI; d_o.alu = a; d_o.dst = 3'd7; d_o.cyc_t = CYCW'(8);
      end
      default: begin
        d_o.cls = CL_RST; d_o.cyc_t = CYCW'(16);
      end
    endcase
    if (!d_o.cond_used) d_o.cyc_n = d_o.cyc_t;
  end
endmodule

// File: rtl/opdec_core.sv
module opdec_core
  import opdec_pkg::*;
#(
  parameter int unsigned VECW = 8
) (
  input  logic [7:0]      opcode_i,
  input  logic            zf_i,
  input  logic            cf_i,
  output logic [4:0]      class_o,
  output logic [2:0]      src_o,
  output logic [2:0]      dst_o,
  output logic [2:0]      alu_op_o,
  output logic [1:0]      cond_o,
  output logic            cond_used_o,
  output logic            taken_o,
  output logic [CYCW-1:0] cyc_taken_o,
  output logic [CYCW-1:0] cyc_skip_o,
  output logic [CYCW-1:0] cyc_o,
  output logic [VECW-1:0] rst_vec_o,
  output logic            hp_c_o,
  output logic            prefix_o,
  output logic            ime_set_o,
  output logic            ime_clr_o,
  output logic            illegal_o
);
  localparam int unsigned VSH = 3;

  dec_t d_lo, d_hi, d;
  logic hold;

  opdec_lo u_lo (.op_i(opcode_i), .d_o(d_lo));
  opdec_hi u_hi (.op_i(opcode_i[5:0]), .d_o(d_hi));
  opdec_cond u_cond (.zf_i(zf_i), .cf_i(cf_i), .sel_i(opcode_i[4:3]), .hold_o(hold));

  assign d = (opcode_i[7:6] == 2'b11) ? d_hi : d_lo;

  assign class_o     = d.cls;
  assign src_o       = d.src;
  assign dst_o       = d.dst;
  assign alu_op_o    = d.alu;
  assign cond_used_o = d.cond_used;
  assign cond_o      = d.cond_used ? opcode_i[4:3] : 2'b00;
  assign taken_o     = d.cond_used & hold;
  assign cyc_taken_o = d.cyc_t;
  assign cyc_skip_o  = d.cyc_n;
  assign cyc_o       = (d.cond_used && !hold) ? d.cyc_n : d.cyc_t;
  assign rst_vec_o   = (d.cls == CL_RST) ? (VECW'(opcode_i[5:3]) << VSH) : '0;
  assign hp_c_o      = d.hp_c;
  assign prefix_o    = d.prefix;
  assign ime_set_o   = d.ime_set;
  assign ime_clr_o   = d.ime_clr;
  assign illegal_o   = d.illegal;
endmodule

// File: rtl/opdec_chk.sv
module opdec_chk
  import opdec_pkg::*;
#(
  parameter int unsigned VECW = 8
) (
  input logic [7:0]      opcode_i,
  input logic            zf_i,
  input logic            cf_i,
  input logic [4:0]      class_o,
  input logic [2:0]      src_o,
  input logic [2:0]      dst_o,
  input logic [2:0]      alu_op_o,
  input logic [1:0]      cond_o,
  input logic            cond_used_o,
  input logic            taken_o,
  input logic [CYCW-1:0] cyc_taken_o,
  input logic [CYCW-1:0] cyc_skip_o,
  input logic [CYCW-1:0] cyc_o,
  input logic [VECW-1:0] rst_vec_o,
  input logic            hp_c_o,
  input logic            prefix_o,
  input logic            ime_set_o,
  input logic            ime_clr_o,
  input logic            illegal_o
);
  always_comb begin
    a_r10_illegal_quiet: assert (!illegal_o || (class_o == 5'd0 && cyc_o == '0 && !cond_used_o));
    a_r4_taken_needs_cond: assert (!taken_o || cond_used_o);
    a_r5_taken_costlier: assert (!cond_used_o || cyc_taken_o > cyc_skip_o);
    a_r6_uncond_flat: assert (cond_used_o || cyc_taken_o == cyc_skip_o);
    a_r7_rst_target: assert (class_o != 5'd13 || rst_vec_o == VECW'({opcode_i[5:3], 3'b000}));
    a_r9_ime_excl: assert (!(ime_set_o && ime_clr_o));
    a_r1_move_cost: assert (class_o != 5'd3 || cyc_o == CYCW'(4) || cyc_o == CYCW'(8));
    a_r5_cost_pick: assert (cyc_o == cyc_taken_o || cyc_o == cyc_skip_o);
  end
endmodule

bind opdec_core opdec_chk #(.VECW(VECW)) u_chk (.*);

// File: tb/tb_opdec_core.sv
module tb_opdec_core;
  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] opcode_i = 8'h00;
  logic zf_i = 1'b0, cf_i = 1'b0;
  logic [4:0] class_o;
  logic [2:0] src_o, dst_o, alu_op_o;
  logic [1:0] cond_o;
  logic cond_used_o, taken_o, hp_c_o, prefix_o, ime_set_o, ime_clr_o, illegal_o;
  logic [4:0] cyc_taken_o, cyc_skip_o, cyc_o;
  logic [7:0] rst_vec_o;

  opdec_core dut (.*);

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  typedef struct {
    int cls, src, dst, alu, cu, ct, cn, hp, pf, is, ic, il, vec;
  } exp_t;

  function automatic exp_t ref_dec(int op);
    exp_t e;
    int g = op >> 6, a = (op >> 3) & 7, b = op & 7;
    e = '{default: 0};
    if (op == 'h76) begin e.cls = 4; e.ct = 4; end
    else if (g == 1) begin
      e.cls = 3; e.dst = a; e.src = b; e.ct = (a == 6 || b == 6) ? 8 : 4;
    end else if (g == 2) begin
      e.cls = 5; e.alu = a; e.src = b; e.dst = 7; e.ct = (b == 6) ? 8 : 4;
    end else if (g == 0) begin
      e.cls = 2;
      if (op == 'h00) begin e.cls = 1; e.ct = 4; end
      else if (op == 'h08) e.ct = 20;
      else if (op == 'h10) e.ct = 4;
      else if (op == 'h18) begin e.cls = 7; e.ct = 12; end
      else if (op == 'h20 || op == 'h28 || op == 'h30 || op == 'h38) begin
        e.cls = 7; e.cu = 1; e.ct = 12; e.cn = 8;
      end
      else if (b == 1) e.ct = (a % 2 == 1) ? 8 : 12;
      else if (b == 2 || b == 3) e.ct = 8;
      else if (b == 4 || b == 5) e.ct = (a == 6) ? 12 : 4;
      else if (b == 6) e.ct = (a == 6) ? 12 : 8;
      else e.ct = 4;
    end else begin
      case (op)
        'hC0, 'hC8, 'hD0, 'hD8: begin e.cls = 11; e.cu = 1; e.ct = 20; e.cn = 8; end
        'hC2, 'hCA, 'hD2, 'hDA: begin e.cls = 8; e.cu = 1; e.ct = 16; e.cn = 12; end
        'hC4, 'hCC, 'hD4, 'hDC: begin e.cls = 10; e.cu = 1; e.ct = 24; e.cn = 12; end
        'hE0: begin e.cls = 16; e.ct = 12; end
        'hF0: begin e.cls = 17; e.ct = 12; end
        'hE2: begin e.cls = 16; e.ct = 8; e.hp = 1; end
        'hF2: begin e.cls = 17; e.ct = 8; e.hp = 1; end
        'hE8, 'hEA, 'hFA: begin e.cls = 2; e.ct = 16; end
        'hF8: begin e.cls = 2; e.ct = 12; end
        'hF9: begin e.cls = 2; e.ct = 8; end
        'hC1, 'hD1, 'hE1, 'hF1: begin e.cls = 15; e.ct = 12; e.dst = a / 2; end
        'hC5, 'hD5, 'hE5, 'hF5: begin e.cls = 14; e.ct = 16; e.src = a / 2; end
        'hC9: begin e.cls = 11; e.ct = 16; end
        'hD9: begin e.cls = 12; e.ct = 16; e.is = 1; end
        'hE9: begin e.cls = 9; e.ct = 4; end
        'hC3: begin e.cls = 8; e.ct = 16; end
        'hCD: begin e.cls = 10; e.ct = 24; end
        'hCB: begin e.cls = 18; e.ct = 4; e.pf = 1; end
        'hF3: begin e.cls = 19; e.ct = 4; e.ic = 1; end
        'hFB: begin e.cls = 20; e.ct = 4; e.is = 1; end
        default: begin
          if (b == 6) begin e.cls = 6; e.alu = a; e.dst = 7; e.ct = 8; end
          else if (b == 7) begin e.cls = 13; e.ct = 16; e.vec = a * 8; end
          else e.il = 1;
        end
      endcase
    end
    if (e.cu == 0) e.cn = e.ct;
    return e;
  endfunction

  function automatic string tag_of(int cls, int il);
    if (il != 0) return "R10";
    case (cls)
      1, 2: return "R11";
      3: return "R1";
      4: return "R2";
      5, 6: return "R3";
      7, 8, 9, 10, 11, 12: return "R5_R6";
      13: return "R7";
      14, 15: return "R12";
      16, 17: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string what, string req, int op, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s op=%02h zc=%0d%0d act=%0d exp=%0d", req, what, op, zf_i, cf_i, act, exp);
    end
  endtask

  task automatic run_vec(int op, int z, int c);
    exp_t e;
    int hold, ctk, cy;
    @(posedge clk);
    opcode_i = 8'(op); zf_i = z[0]; cf_i = c[0];
    @(negedge clk);
    e = ref_dec(op);
    // R4: 0 zero clear, 1 zero set, 2 carry clear, 3 carry set
    case ((op >> 3) & 3)
      0: hold = (z == 0); 1: hold = (z == 1);
      2: hold = (c == 0); default: hold = (c == 1);
    endcase
    ctk = (e.cu != 0 && hold != 0) ? 1 : 0;
    cy  = (e.cu != 0 && hold == 0) ? e.cn : e.ct;
    chk("class",  tag_of(e.cls, e.il), op, int'(class_o), e.cls);
    chk("src",    tag_of(e.cls, e.il), op, int'(src_o), e.src);
    chk("dst",    tag_of(e.cls, e.il), op, int'(dst_o), e.dst);
    chk("alu",    "R3",  op, int'(alu_op_o), e.alu);
    chk("cu",     "R4",  op, int'(cond_used_o), e.cu);
    chk("cond",   "R4",  op, int'(cond_o), (e.cu != 0) ? ((op >> 3) & 3) : 0);
    chk("taken",  "R4",  op, int'(taken_o), ctk);
    chk("cyc_t",  tag_of(e.cls, e.il), op, int'(cyc_taken_o), e.ct);
    chk("cyc_n",  "R6",  op, int'(cyc_skip_o), e.cn);
    chk("cyc",    "R5",  op, int'(cyc_o), cy);
    chk("vec",    "R7",  op, int'(rst_vec_o), e.vec);
    chk("hp_c",   "R8",  op, int'(hp_c_o), e.hp);
    chk("prefix", "R9",  op, int'(prefix_o), e.pf);
    chk("ime_set","R9",  op, int'(ime_set_o), e.is);
    chk("ime_clr","R9",  op, int'(ime_clr_o), e.ic);
    chk("illegal","R10", op, int'(illegal_o), e.il);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state: opcode 0x00 is the no-op, R11
    chk("class", "R11", 0, int'(class_o), 1);
    chk("cyc",   "R11", 0, int'(cyc_o), 4);
    for (int fz = 0; fz < 4; fz++) begin
      for (int op = 0; op < 256; op++) begin
        run_vec(op, fz >> 1, fz & 1);
      end
    end
    // corner: conditional call, carry-set condition with carry clear then set, R5
    run_vec('hDC, 0, 0);
    chk("cyc", "R5", 'hDC, int'(cyc_o), 12);
    run_vec('hDC, 0, 1);
    chk("cyc", "R5", 'hDC, int'(cyc_o), 24);
    done = 1'b1;
  end

  initial begin
    int cnt = 0;
    while (!done && cnt < 100000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
    end
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule